// File: doc/BRIEF.md
# Switch MAC Address Table Engine

This block is the forwarding database of a small Ethernet switch. It keeps up to `DEPTH` entries. Each entry holds a database number, a 48-bit MAC address, a 4-bit entry state, a trunk flag and a per-port membership vector. Software reaches the table only through a bank of 16-bit registers: three words of MAC address, one data word and one operation word.

To run a command, software fills the argument registers and then writes the operation word with its busy bit set. The engine then scans the table one entry per cycle and clears busy when it finishes. While busy is high, every register write is dropped.

Four kinds of command are available:
- Load or purge a single entry.
- Return the next entry of one database in ascending address order.
- Flush entries in bulk.
- Move a port's membership in bulk.

A getnext call starts from the address in the MAC registers and leaves its result there. Repeated calls therefore walk a whole database without software writing the MAC registers again.

Top module: `mac_table_engine`

## Requirements
- R1: After reset, all five registers read as zero, busy is low, and a walk of any database returns the end marker straight away.
- R2: Register addresses are: 0 operation, 1 data, 2, 3 and 4 MAC words. MAC word 2 holds bytes 0 and 1, word 3 holds bytes 2 and 3, word 4 holds bytes 4 and 5, with the lower-numbered byte in bits 15:8. Address order treats byte 0 as the most significant.
- R3: A command raises busy on the clock edge that accepts it. Busy falls no more than `DEPTH`+3 cycles later, and the registers are then ready for the next command.
- R4: A write to any register while busy is high has no effect.
- R5: Load is opcode 3. With a nonzero data state (data bits 3:0) it creates the entry for {database, MAC}, or overwrites that entry if it already exists. The stored entry takes the data word's port vector (bits 11:4) and trunk flag (bit 15). With state zero, load removes the matching entry.
- R6: Getnext is opcode 4. It returns the entry of the selected database with the smallest MAC address above the address in the MAC registers. An all-ones start address selects the smallest entry. The result is placed in the MAC and data registers, and entries of other databases are never returned.
- R7: When getnext finds no further entry, the MAC registers become all-ones and the data word becomes zero.
- R8: Flush/move opcodes come in two kinds. Opcodes 1 and 5 touch all entries. Opcodes 2 and 6 skip static entries, which are those with state 4'hF.
- R9: Opcodes 1 and 2 cover every database. Opcodes 5 and 6 cover only the database in the operation word.
- R10: A flush/move command acts according to the data state:
  - State zero removes every selected entry.
  - State 4'hF moves a port. Data bits 7:4 give the source port and bits 11:8 the destination port. Each selected entry whose vector contains the source port loses that port and gains the destination port. A destination of 4'hF only removes the port, and an entry whose vector becomes empty is removed.
  - Any other state leaves the table unchanged.
- R11: The 6-bit database number is carried in operation-word bits 9:8 (upper two bits) and bits 3:0 (lower four bits). Bits 14:12 carry the opcode and bit 15 is busy.
- R12: When every slot is in use, a load of a new address leaves the table unchanged, while a load that overwrites an existing address still succeeds.
- R13: Writing the operation word with bit 15 clear, or with opcode 0 or 7, only stores the fields and starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Registered read data, valid one cycle after rd_addr |
| busy | output | 1 | High while a command runs |

## Verification
The bench walks each database after every batch of commands and compares each returned entry with a reference model.

The corner cases it targets, and how a faulty design would fail them:
- **Address order:** a design that compared the MAC bytes in the wrong significance would return entries out of order.
- **Walk continuation:** a design that did not resume from the last result would loop on one entry or skip entries.
- **End of table:** a design with a wrong end marker would never terminate a walk.
- **Non-static flush:** a design that ignored the non-static qualifier would delete static entries.
- **Database scope:** a design that ignored the scope would delete entries in other databases.
- **Remove-only move:** a design that mishandled a destination of 4'hF would set a phantom port, or leave behind an entry whose vector is empty.
- **Full table:** a full table must still accept an overwrite but must drop a new address.
- **Writes while busy:** writes issued during a command must not corrupt its arguments.

// File: rtl/mat_pkg.sv
package mat_pkg;
  localparam int MAC_W = 48;
  localparam int DB_W  = 6;
  localparam int ST_W  = 4;
  localparam int REG_W = 16;
  localparam int RA_W  = 3;

  typedef enum logic [2:0] {
    OP_NOP          = 3'd0,
    OP_FLUSH_ALL    = 3'd1,
    OP_FLUSH_NS     = 3'd2,
    OP_LOAD         = 3'd3,
    OP_NEXT         = 3'd4,
    OP_FLUSH_ALL_DB = 3'd5,
    OP_FLUSH_NS_DB  = 3'd6,
    OP_RSVD         = 3'd7
  } op_e;

  localparam logic [RA_W-1:0] A_OP   = 3'd0;
  localparam logic [RA_W-1:0] A_DATA = 3'd1;
  localparam logic [RA_W-1:0] A_MAC0 = 3'd2;
  localparam logic [RA_W-1:0] A_MAC1 = 3'd3;
  localparam logic [RA_W-1:0] A_MAC2 = 3'd4;

  localparam logic [ST_W-1:0] ST_EMPTY  = 4'h0;
  localparam logic [ST_W-1:0] ST_STATIC = 4'hF;
endpackage

// File: rtl/mat_store.sv
module mat_store #(
  parameter int W     = 64,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic          wvalid,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr,
  output logic          rvalid,
  output logic [W-1:0]  rdata
);
  // Entry payload in a plain memory (no reset), valid flags in flops.
  logic [W-1:0]     mem [DEPTH];
  logic [DEPTH-1:0] vld;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (we) vld[waddr] <= wvalid;
  end

  assign rdata  = mem[raddr];
  assign rvalid = vld[raddr];
endmodule

// File: rtl/mat_regs.sv
module mat_regs
  import mat_pkg::*;
#(
  parameter int NPORTS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [RA_W-1:0]   wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [RA_W-1:0]   rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              eng_done,
  input  logic              res_we,
  input  logic [MAC_W-1:0]  res_mac,
  input  logic [ST_W-1:0]   res_state,
  input  logic              res_trunk,
  input  logic [NPORTS-1:0] res_pv,
  output logic              busy,
  output logic              go,
  output logic [2:0]        cmd_op,
  output logic [DB_W-1:0]   cmd_db,
  output logic [MAC_W-1:0]  cmd_mac,
  output logic [ST_W-1:0]   cmd_state,
  output logic              cmd_trunk,
  output logic [NPORTS-1:0] cmd_pv
);
  logic             op_ok;
  logic [REG_W-1:0] op_word, data_word, rd_mux;

  assign op_ok = (wr_data[14:12] != OP_NOP) && (wr_data[14:12] != OP_RSVD);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      go        <= 1'b0;
      cmd_op    <= '0;
      cmd_db    <= '0;
      cmd_mac   <= '0;
      cmd_state <= '0;
      cmd_trunk <= 1'b0;
      cmd_pv    <= '0;
    end else begin
      go <= 1'b0;
      if (eng_done) busy <= 1'b0;
      if (res_we) begin
        cmd_mac   <= res_mac;
        cmd_state <= res_state;
        cmd_trunk <= res_trunk;
        cmd_pv    <= res_pv;
      end
      if (wr_en && !busy) begin
        case (wr_addr)
          A_OP: begin
            cmd_op <= wr_data[14:12];
            cmd_db <= {wr_data[9:8], wr_data[3:0]};
            if (wr_data[15] && op_ok) begin
              busy <= 1'b1;
              go   <= 1'b1;
            end
          end
          A_DATA: begin
            cmd_state <= wr_data[3:0];
            cmd_pv    <= wr_data[4 +: NPORTS];
            cmd_trunk <= wr_data[15];
          end
          A_MAC0:  cmd_mac[47:32] <= wr_data;
          A_MAC1:  cmd_mac[31:16] <= wr_data;
          A_MAC2:  cmd_mac[15:0]  <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    op_word        = '0;
    op_word[15]    = busy;
    op_word[14:12] = cmd_op;
    op_word[9:8]   = cmd_db[5:4];
    op_word[3:0]   = cmd_db[3:0];
    data_word              = '0;
    data_word[3:0]         = cmd_state;
    data_word[4 +: NPORTS] = cmd_pv;
    data_word[15]          = cmd_trunk;
    case (rd_addr)
      A_OP:    rd_mux = op_word;
      A_DATA:  rd_mux = data_word;
      A_MAC0:  rd_mux = cmd_mac[47:32];
      A_MAC1:  rd_mux = cmd_mac[31:16];
      A_MAC2:  rd_mux = cmd_mac[15:0];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/mat_engine.sv
module mat_engine
  import mat_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int NPORTS = 8,
  localparam int IW    = $clog2(DEPTH),
  localparam int EW    = DB_W + MAC_W + ST_W + 1 + NPORTS,
  localparam int MVW   = NPORTS / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [2:0]        cmd_op,
  input  logic [DB_W-1:0]   cmd_db,
  input  logic [MAC_W-1:0]  cmd_mac,
  input  logic [ST_W-1:0]   cmd_state,
  input  logic              cmd_trunk,
  input  logic [NPORTS-1:0] cmd_pv,
  output logic [IW-1:0]     st_raddr,
  input  logic              st_rvalid,
  input  logic [EW-1:0]     st_rdata,
  output logic              st_we,
  output logic [IW-1:0]     st_waddr,
  output logic              st_wvalid,
  output logic [EW-1:0]     st_wdata,
  output logic              done,
  output logic              res_we,
  output logic [MAC_W-1:0]  res_mac,
  output logic [ST_W-1:0]   res_state,
  output logic              res_trunk,
  output logic [NPORTS-1:0] res_pv
);
  typedef enum logic [1:0] {E_IDLE, E_SCAN, E_DONE} phase_e;

  phase_e           phase;
  logic [IW-1:0]    idx, match_idx, free_idx, best_idx;
  logic             match_hit, free_hit, best_hit;
  logic [MAC_W-1:0] best_mac;

  // Fields of the entry currently presented by the store.
  logic [DB_W-1:0]   e_db;
  logic [MAC_W-1:0]  e_mac;
  logic [ST_W-1:0]   e_state;
  logic              e_trunk;
  logic [NPORTS-1:0] e_pv;

  assign e_db    = st_rdata[EW-1 -: DB_W];
  assign e_mac   = st_rdata[NPORTS+1+ST_W +: MAC_W];
  assign e_state = st_rdata[NPORTS+1 +: ST_W];
  assign e_trunk = st_rdata[NPORTS];
  assign e_pv    = st_rdata[NPORTS-1:0];

  // Command decode.
  logic is_load, is_next, is_flush, db_only, ns_only;
  assign is_load  = (cmd_op == OP_LOAD);
  assign is_next  = (cmd_op == OP_NEXT);
  assign db_only  = (cmd_op == OP_FLUSH_ALL_DB) || (cmd_op == OP_FLUSH_NS_DB);
  assign ns_only  = (cmd_op == OP_FLUSH_NS) || (cmd_op == OP_FLUSH_NS_DB);
  assign is_flush = db_only || ns_only || (cmd_op == OP_FLUSH_ALL);

  // Move port arguments packed into the command port vector.
  logic [MVW-1:0]    mv_from, mv_to;
  logic [NPORTS-1:0] from_oh, to_oh, mv_new;
  assign mv_from = cmd_pv[MVW-1:0];
  assign mv_to   = cmd_pv[2*MVW-1:MVW];
  assign from_oh = {{(NPORTS-1){1'b0}}, 1'b1} << mv_from;
  assign to_oh   = (mv_to == {MVW{1'b1}}) ? '0 : ({{(NPORTS-1){1'b0}}, 1'b1} << mv_to);
  assign mv_new  = (e_pv & ~from_oh) | to_oh;

  // Per-entry flush/move action.
  logic          sel, fl_we, fl_wvalid;
  logic [EW-1:0] fl_wdata;
  always_comb begin
    sel = st_rvalid && (!db_only || e_db == cmd_db) && (!ns_only || e_state != ST_STATIC);
    fl_we     = 1'b0;
    fl_wvalid = 1'b0;
    fl_wdata  = st_rdata;
    if (sel && cmd_state == ST_EMPTY) begin
      fl_we = 1'b1;
    end else if (sel && cmd_state == ST_STATIC && (e_pv & from_oh) != '0) begin
      fl_we     = 1'b1;
      fl_wvalid = (mv_new != '0);
      fl_wdata  = {e_db, e_mac, e_state, e_trunk, mv_new};
    end
  end

  // Load commit decision.
  logic          ld_we, ld_wvalid;
  logic [IW-1:0] ld_idx;
  always_comb begin
    ld_we     = 1'b0;
    ld_wvalid = 1'b0;
    ld_idx    = match_idx;
    if (cmd_state == ST_EMPTY) begin
      ld_we = match_hit;
    end else if (match_hit) begin
      ld_we     = 1'b1;
      ld_wvalid = 1'b1;
    end else if (free_hit) begin
      ld_we     = 1'b1;
      ld_wvalid = 1'b1;
      ld_idx    = free_idx;
    end
  end

  logic key_hit, next_cand;
  assign key_hit   = st_rvalid && e_db == cmd_db && e_mac == cmd_mac;
  assign next_cand = st_rvalid && e_db == cmd_db &&
                     (cmd_mac == {MAC_W{1'b1}} || e_mac > cmd_mac) &&
                     (!best_hit || e_mac < best_mac);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= E_IDLE;
      idx       <= '0;
      match_hit <= 1'b0;
      free_hit  <= 1'b0;
      best_hit  <= 1'b0;
      match_idx <= '0;
      free_idx  <= '0;
      best_idx  <= '0;
      best_mac  <= '0;
    end else begin
      case (phase)
        E_IDLE: if (go) begin
          phase     <= E_SCAN;
          idx       <= '0;
          match_hit <= 1'b0;
          free_hit  <= 1'b0;
          best_hit  <= 1'b0;
        end
        E_SCAN: begin
          if (key_hit) begin
            match_hit <= 1'b1;
            match_idx <= idx;
          end
          if (!st_rvalid && !free_hit) begin
            free_hit <= 1'b1;
            free_idx <= idx;
          end
          if (next_cand) begin
            best_hit <= 1'b1;
            best_idx <= idx;
            best_mac <= e_mac;
          end
          if (idx == IW'(DEPTH - 1)) phase <= E_DONE;
          else                       idx   <= idx + 1'b1;
        end
        default: phase <= E_IDLE;
      endcase
    end
  end

  assign done      = (phase == E_DONE);
  assign st_raddr  = done ? best_idx : idx;
  assign st_we     = (phase == E_SCAN && is_flush && fl_we) || (done && is_load && ld_we);
  assign st_waddr  = done ? ld_idx : idx;
  assign st_wvalid = done ? ld_wvalid : fl_wvalid;
  assign st_wdata  = done ? {cmd_db, cmd_mac, cmd_state, cmd_trunk, cmd_pv} : fl_wdata;

  assign res_we    = done && is_next;
  assign res_mac   = best_hit ? e_mac   : {MAC_W{1'b1}};
  assign res_state = best_hit ? e_state : ST_EMPTY;
  assign res_trunk = best_hit && e_trunk;
  assign res_pv    = best_hit ? e_pv    : '0;
endmodule

// File: rtl/mac_table_engine.sv
module mac_table_engine
  import mat_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int NPORTS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [RA_W-1:0]   wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [RA_W-1:0]   rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              busy
);
  localparam int IW = $clog2(DEPTH);
  localparam int EW = DB_W + MAC_W + ST_W + 1 + NPORTS;

  logic              go, eng_done, res_we, res_trunk, cmd_trunk;
  logic [2:0]        cmd_op;
  logic [DB_W-1:0]   cmd_db;
  logic [MAC_W-1:0]  cmd_mac, res_mac;
  logic [ST_W-1:0]   cmd_state, res_state;
  logic [NPORTS-1:0] cmd_pv, res_pv;
  logic [IW-1:0]     st_raddr, st_waddr;
  logic              st_rvalid, st_we, st_wvalid;
  logic [EW-1:0]     st_rdata, st_wdata;

  mat_regs #(.NPORTS(NPORTS)) regs_i (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .eng_done, .res_we, .res_mac, .res_state, .res_trunk, .res_pv,
    .busy, .go, .cmd_op, .cmd_db, .cmd_mac, .cmd_state, .cmd_trunk, .cmd_pv
  );

  mat_engine #(.DEPTH(DEPTH), .NPORTS(NPORTS)) eng_i (
    .clk, .rst, .go, .cmd_op, .cmd_db, .cmd_mac, .cmd_state, .cmd_trunk, .cmd_pv,
    .st_raddr, .st_rvalid, .st_rdata, .st_we, .st_waddr, .st_wvalid, .st_wdata,
    .done(eng_done), .res_we, .res_mac, .res_state, .res_trunk, .res_pv
  );

  mat_store #(.W(EW), .DEPTH(DEPTH)) store_i (
    .clk, .rst, .we(st_we), .waddr(st_waddr), .wvalid(st_wvalid), .wdata(st_wdata),
    .raddr(st_raddr), .rvalid(st_rvalid), .rdata(st_rdata)
  );
endmodule

// File: rtl/mac_table_engine_chk.sv
module mac_table_engine_chk #(
  parameter int DEPTH = 16
) (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic [15:0] wr_data,
  input logic        busy,
  input logic        eng_done,
  input logic        st_we,
  input logic        res_we,
  input logic [47:0] cmd_mac
);
  logic [15:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (rst || !busy) busy_cnt <= '0;
    else              busy_cnt <= busy_cnt + 1'b1;
  end

  // R3: busy never lasts beyond the scan plus a fixed overhead
  a_r3_busy_bounded: assert property (@(posedge clk) disable iff (rst)
    busy_cnt <= 16'(DEPTH + 3));

  // R3: completion of the engine releases busy
  a_r3_done_clears: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> !busy);

  // R13: a command only starts from a write of the operation word with bit 15 set
  a_r13_start_from_write: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_en && wr_addr == 3'd0 && wr_data[15]));

  // R4: command address cannot be changed by software while busy
  a_r4_mac_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && !res_we) |=> $stable(cmd_mac));

  // R5: the table is only written inside a command
  a_r5_write_in_cmd: assert property (@(posedge clk) disable iff (rst)
    st_we |-> busy);
endmodule

bind mac_table_engine mac_table_engine_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .busy(busy), .eng_done(eng_done), .st_we(st_we), .res_we(res_we), .cmd_mac(cmd_mac)
);

// File: tb/mac_table_engine_tb_top.sv
module mac_table_engine_tb_top;
  localparam int DEPTH  = 16;
  localparam int NPORTS = 8;
  localparam logic [2:0] F_ALL = 3'd1, F_NS = 3'd2, LOAD = 3'd3, NEXT = 3'd4,
                         F_ALL_DB = 3'd5, F_NS_DB = 3'd6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        busy;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  mac_table_engine #(.DEPTH(DEPTH), .NPORTS(NPORTS)) dut_i (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data, .busy
  );

  // Reference model
  logic        m_v  [DEPTH];
  logic [5:0]  m_db [DEPTH];
  logic [47:0] m_mac[DEPTH];
  logic [3:0]  m_st [DEPTH];
  logic        m_tr [DEPTH];
  logic [7:0]  m_pv [DEPTH];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  function automatic logic [15:0] op_word(input logic go, input logic [2:0] op, input logic [5:0] db);
    return {go, op, 2'b00, db[5:4], 4'h0, db[3:0]};
  endfunction

  task automatic wait_idle(input string tag);
    int n;
    for (n = 0; n < 200; n++) begin
      if (!busy) break;
      @(negedge clk);
    end
    check({tag, " busy released"}, 64'(n <= DEPTH + 3), 64'd1);
  endtask

  task automatic cmd(input logic [2:0] op, input logic [5:0] db);
    wr(3'd0, op_word(1'b1, op, db));
    wait_idle("R3");
  endtask

  task automatic set_mac(input logic [47:0] m);
    wr(3'd2, m[47:32]); wr(3'd3, m[31:16]); wr(3'd4, m[15:0]);
  endtask

  task automatic set_data(input logic [3:0] st, input logic tr, input logic [7:0] pv);
    wr(3'd1, {tr, 3'b000, pv, st});
  endtask

  task automatic model_load(input logic [5:0] db, input logic [47:0] mac,
                            input logic [3:0] st, input logic tr, input logic [7:0] pv);
    int hit = -1, fr = -1;
    for (int i = 0; i < DEPTH; i++) begin
      if (m_v[i] && m_db[i] == db && m_mac[i] == mac) hit = i;
      if (!m_v[i] && fr < 0) fr = i;
    end
    if (st == 4'h0) begin
      if (hit >= 0) m_v[hit] = 1'b0;
    end else begin
      if (hit < 0) hit = fr;
      if (hit >= 0) begin
        m_v[hit] = 1'b1; m_db[hit] = db; m_mac[hit] = mac;
        m_st[hit] = st; m_tr[hit] = tr; m_pv[hit] = pv;
      end
    end
  endtask

  task automatic load(input logic [5:0] db, input logic [47:0] mac,
                      input logic [3:0] st, input logic tr, input logic [7:0] pv);
    set_mac(mac); set_data(st, tr, pv); cmd(LOAD, db);
    model_load(db, mac, st, tr, pv);
  endtask

  task automatic model_flush(input logic [2:0] op, input logic [5:0] db,
                             input logic [3:0] st, input logic [7:0] pv);
    logic dbo, nso, s;
    logic [3:0] fr, to;
    logic [7:0] nv;
    dbo = (op == F_ALL_DB) || (op == F_NS_DB);
    nso = (op == F_NS) || (op == F_NS_DB);
    fr = pv[3:0]; to = pv[7:4];
    for (int i = 0; i < DEPTH; i++) begin
      s = m_v[i] && (!dbo || m_db[i] == db) && (!nso || m_st[i] != 4'hF);
      if (s && st == 4'h0) m_v[i] = 1'b0;
      else if (s && st == 4'hF && fr < 8 && m_pv[i][fr[2:0]]) begin
        nv = m_pv[i];
        nv[fr[2:0]] = 1'b0;
        if (to < 8) nv[to[2:0]] = 1'b1;
        m_pv[i] = nv;
        if (nv == 8'h00) m_v[i] = 1'b0;
      end
    end
  endtask

  task automatic flush(input logic [2:0] op, input logic [5:0] db,
                       input logic [3:0] st, input logic [7:0] pv);
    set_data(st, 1'b0, pv); cmd(op, db);
    model_flush(op, db, st, pv);
  endtask

  function automatic int model_next(input logic [5:0] db, input logic [47:0] prev);
    int b = -1;
    for (int i = 0; i < DEPTH; i++)
      if (m_v[i] && m_db[i] == db && (prev == '1 || m_mac[i] > prev) &&
          (b < 0 || m_mac[i] < m_mac[b])) b = i;
    return b;
  endfunction

  // R6 R7: full walk of one database compared with the model
  task automatic walk(input logic [5:0] db, input string tag);
    logic [47:0] prev, gm;
    logic [15:0] w0, w1, w2, dw;
    int b;
    prev = '1;
    set_mac('1);
    for (int n = 0; n < DEPTH + 2; n++) begin
      cmd(NEXT, db);
      rd(3'd2, w0); rd(3'd3, w1); rd(3'd4, w2); rd(3'd1, dw);
      gm = {w0, w1, w2};
      b = model_next(db, prev);
      if (b >= 0) begin
        check({tag, " R6 mac"}, 64'(gm), 64'(m_mac[b]));
        check({tag, " R6 data"}, 64'(dw), 64'({m_tr[b], 3'b000, m_pv[b], m_st[b]}));
        prev = m_mac[b];
      end else begin
        check({tag, " R7 end mac"}, 64'(gm), 64'({48{1'b1}}));
        check({tag, " R7 end data"}, 64'(dw), 64'd0);
        break;
      end
    end
  endtask

  initial begin
    logic [15:0] d;
    logic [47:0] mac;
    for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      check("R1 register reset", 64'(d), 64'd0);
    end
    check("R1 busy reset", 64'(busy), 64'd0);
    walk(6'd0, "R1 empty");

    // R11 R13: operation word field placement, no start without bit 15
    wr(3'd0, op_word(1'b0, LOAD, 6'h2A));
    rd(3'd0, d);
    check("R11 op word fields", 64'(d), 64'h320A);
    check("R13 no start", 64'(busy), 64'd0);
    wr(3'd0, op_word(1'b1, 3'd7, 6'h01));
    check("R13 reserved op", 64'(busy), 64'd0);

    // R5 R2: loads, ordering by byte 0 as most significant
    load(6'd5, 48'h0200_0000_0001, 4'h7, 1'b0, 8'h04);
    load(6'd5, 48'h0100_FFFF_FFFF, 4'hF, 1'b1, 8'h24);
    load(6'd5, 48'h0100_0000_0002, 4'h3, 1'b0, 8'h20);
    load(6'd6, 48'h0000_0000_0001, 4'h2, 1'b0, 8'h01);
    load(6'h21, 48'h0000_0000_0009, 4'h5, 1'b0, 8'h02);
    set_mac('1); cmd(NEXT, 6'd5);
    rd(3'd2, d);
    check("R2 first word of smallest", 64'(d), 64'h0100);
    rd(3'd4, d);
    check("R2 last word of smallest", 64'(d), 64'h0002);
    walk(6'd5, "R2 order");
    walk(6'h21, "R11 upper db bits");

    // R4: writes during a command are dropped
    set_mac(48'h0300_0000_0000); set_data(4'h6, 1'b0, 8'h10);
    wr(3'd0, op_word(1'b1, LOAD, 6'd5));
    wr(3'd2, 16'hDEAD);
    wr(3'd1, 16'h0000);
    wait_idle("R4");
    model_load(6'd5, 48'h0300_0000_0000, 4'h6, 1'b0, 8'h10);
    rd(3'd2, d);
    check("R4 mac word kept", 64'(d), 64'h0300);
    rd(3'd1, d);
    check("R4 data kept", 64'(d), 64'h0106);

    // R5: overwrite and purge
    load(6'd5, 48'h0200_0000_0001, 4'h9, 1'b1, 8'h81);
    load(6'd5, 48'h0100_0000_0002, 4'h0, 1'b0, 8'h00);
    walk(6'd5, "R5 overwrite purge");

    // R10: move port 2 to port 5, then remove port 5
    flush(F_ALL_DB, 6'd5, 4'hF, 8'h52);
    walk(6'd5, "R10 move");
    flush(F_ALL_DB, 6'd5, 4'hF, 8'hF5);
    walk(6'd5, "R10 remove");
    flush(F_ALL_DB, 6'd5, 4'h3, 8'h00);
    walk(6'd5, "R10 other state no effect");

    // R8 R9: non-static flush in one db, then flush of all dbs
    flush(F_NS_DB, 6'd5, 4'h0, 8'h00);
    walk(6'd5, "R8 static survives");
    walk(6'd6, "R9 other db kept");
    flush(F_ALL, 6'd0, 4'h0, 8'h00);
    walk(6'd5, "R9 all flushed");
    walk(6'd6, "R9 all flushed");

    // R12: full table
    for (int i = 0; i < DEPTH; i++) load(6'd3, 48'(i * 3 + 1), 4'h4, 1'b0, 8'h01);
    load(6'd3, 48'h0000_0000_0100, 4'h4, 1'b0, 8'h02);
    load(6'd3, 48'h0000_0000_0004, 4'hE, 1'b0, 8'h40);
    walk(6'd3, "R12 full");
    flush(F_ALL, 6'd0, 4'h0, 8'h00);

    // Random phase over a few databases, walked periodically (R5 R6 R8 R9 R10)
    for (int it = 0; it < 240; it++) begin
      int k;
      logic [5:0] db;
      k = $urandom % 10;
      db = 6'($urandom % 3);
      mac = {8'($urandom % 4), 32'h0, 8'($urandom % 12)};
      if (k < 7) load(db, mac, 4'($urandom % 16), 1'($urandom), 8'($urandom));
      else if (k == 7) flush(3'(1 + $urandom % 2), db, 4'h0, 8'h00);
      else if (k == 8) flush(3'(5 + $urandom % 2), db, 4'hF,
                             {4'(($urandom % 3 == 0) ? 15 : $urandom % 8), 4'($urandom % 8)});
      else flush(3'(5 + $urandom % 2), db, 4'h0, 8'h00);
      if (it % 30 == 29)
        for (int b = 0; b < 3; b++) walk(6'(b), "R6 random walk");
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule